// File: doc/BRIEF.md
# Programmable Gate Line Scanner

This block selects one gate line of a display panel at a time. On every line-advance strobe it moves the selection to the next line. A frame sync strobe restarts the scan. Each line output is a two-bit level code: selected (high drive), unselected (off drive) or grounded. The analog level shifting and drive stages sit outside the block and decode these codes.

The scan covers a window of a combined 240-line panel. Two instances split that panel. The instance with `master` high owns global lines 0 to 119, and the other owns lines 120 to 239. Both instances receive the same strobes and settings. The window start and length are given in units of eight lines. The scan can run downward or upward. It runs either as a single progressive field or as three interlaced fields that alternate frame by frame.

Blanking inputs override the scan without waiting for a clock. Two spare outputs can mark the first and the last line of each field. Settings that are inhibited or out of range are clamped to legal values, and a sticky flag records that this happened.

Top module: `gate_line_scanner`

## Requirements
- R1: Level codes are 2'b10 selected, 2'b01 off and 2'b00 ground, with line i on `gate_lvl[2i+1:2i]`. With blanking inactive, at most one line is at 2'b10 and every other line is at 2'b01.
- R2: After a `frame_sync` strobe no line is selected. The first `line_tick` strobe then selects the first line of the field, and every further strobe moves one position in the sequence. When both strobes arrive in the same cycle, the frame sync wins and the line strobe is lost.
- R3: With start code s and length code n, the window covers global lines 8*s to 8*s+8*(n+1)-1, counting from 0.
- R4: With `cfg_rev`=0 the scan runs from the lowest line of the window upward. With `cfg_rev`=1 it runs from the highest line downward.
- R5: With `cfg_fld[1]`=1 the three-field mode is active. Field k scans only the positions whose distance from the first line of the sequence is k mod 3. The first frame after reset uses field 0, and k steps 0,1,2,0 on each frame sync. In single-field mode (`cfg_fld[1]`=0) every position is scanned and the field index returns to 0.
- R6: With `master`=1, local output i shows global line i. With `master`=0, it shows global line 120+i. A selected global line that falls outside this instance leaves all of its outputs off.
- R7: After the last line of the field has been scanned, no line is selected. Further line strobes have no effect until the next frame sync.
- R8: Length code 0 is treated as 1, and codes above 29 as 29. The start code is reduced to at most 29 minus the effective length code. `cfg_fld[0]`=0 is treated as 1. Any such correction at a frame sync sets `cfg_err`, which stays set until reset.
- R9: With `disp_en` low, every gate and spare output is off (2'b01), without waiting for a clock edge. If `gate_on` is also low, they are grounded (2'b00) instead.
- R10: With `sleep` high, every gate and spare output is grounded. The scan position is kept, so the same line is selected again once `sleep` falls.
- R11: With `dummy_en`=0 both spare outputs are off. With `dummy_en`=1, `dummy_lvl[1:0]` is selected while the first line of the field is selected, and `dummy_lvl[3:2]` is selected while the last line is selected.
- R12: The settings are captured only at a frame sync. Changing them in the middle of a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | One-cycle frame restart strobe |
| line_tick | input | 1 | One-cycle line advance strobe |
| master | input | 1 | High: owns the first half of the combined panel |
| disp_en | input | 1 | Display timing; low forces outputs off or to ground |
| sleep | input | 1 | High grounds all outputs |
| gate_on | input | 1 | Low, together with disp_en low, grounds outputs |
| dummy_en | input | 1 | Enables the spare-output markers |
| cfg_start | input | 5 | Window start code, in steps of 8 lines |
| cfg_lines | input | 5 | Window length code, 8*(code+1) lines |
| cfg_rev | input | 1 | Scan direction reverse |
| cfg_fld | input | 2 | Field mode, 2'b01 single, 2'b11 three-field |
| gate_lvl | output | 240 | Two-bit level code per gate line |
| dummy_lvl | output | 4 | Two-bit level codes of the two spare outputs |
| cfg_err | output | 1 | Sticky flag for clamped settings |

## Verification
Random frames mix legal and illegal codes, both directions, both field modes and both instance roles. Every line strobe is compared with a model of the sequence. That comparison catches an end-of-window that is off by one (a line leaks past the window, or the last line is dropped), a reversed scan that starts one line away from the top, and a field index that does not step or does not wrap. Directed cases cover a frame sync and a line strobe in the same cycle, a mid-frame settings change, and blanking applied between clock edges, where a clocked override would show the wrong level. They also cover sleep followed by wake, where a design that lost its position would select another line. Each kind of clamp is exercised, and a flag that clears itself is caught on a later legal frame.

// File: rtl/gls_pkg.sv
package gls_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        LV_GND = 2'b00,
        LV_OFF = 2'b01,
        LV_SEL = 2'b10
    } lvl_e;

    typedef struct packed {
        logic [CODE_W-1:0] sc;
        logic [CODE_W-1:0] nc;
        logic              rev;
        logic              tri3;
    } cfg_s;

    // blanking precedence: sleep, then grounded blank, then off blank
    function automatic lvl_e apply_ovr(lvl_e v, logic slp, logic den, logic gon);
        if (slp)              return LV_GND;
        else if (!den && !gon) return LV_GND;
        else if (!den)        return LV_OFF;
        else                  return v;
    endfunction

endpackage

// File: rtl/gls_cfg_clamp.sv
module gls_cfg_clamp
    import gls_pkg::*;
#(
    parameter int MAX_CODE = 29
) (
    input  logic [CODE_W-1:0] raw_sc,
    input  logic [CODE_W-1:0] raw_nc,
    input  logic              raw_rev,
    input  logic [1:0]        raw_fld,
    output cfg_s              eff,
    output logic              bad
);
    localparam logic [CODE_W-1:0] MAXC = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] nc_e, sc_lim, sc_e;

    always_comb begin
        if (raw_nc == '0)       nc_e = CODE_W'(1);
        else if (raw_nc > MAXC) nc_e = MAXC;
        else                    nc_e = raw_nc;
        sc_lim = MAXC - nc_e;
        sc_e   = (raw_sc > sc_lim) ? sc_lim : raw_sc;
        eff.sc   = sc_e;
        eff.nc   = nc_e;
        eff.rev  = raw_rev;
        eff.tri3 = raw_fld[1];
        bad = (nc_e != raw_nc) || (sc_e != raw_sc) || !raw_fld[0];
    end
endmodule

// File: rtl/gls_seq.sv
module gls_seq
    import gls_pkg::*;
#(
    parameter int TOTAL = 240,
    parameter int STEP  = 8,
    parameter int LW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_sync,
    input  logic          line_tick,
    input  cfg_s          cfg_eff,
    input  logic          cfg_bad,
    output logic          sel_valid,
    output logic [LW-1:0] sel_line,
    output logic          is_first,
    output logic          is_last,
    output logic          cfg_err
);
    logic [LW-1:0] t_q, cnt_q, base_q, offs;
    logic [1:0]    tstart_q, fld_q, step_q;
    logic          rev_q, armed_q, act_q, err_q;
    logic [LW:0]   t_next;

    assign t_next = {1'b0, t_q} + (LW+1)'(step_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q      <= '0;
            cnt_q    <= LW'(TOTAL);
            base_q   <= '0;
            tstart_q <= '0;
            fld_q    <= '0;
            step_q   <= 2'd1;
            rev_q    <= 1'b0;
            armed_q  <= 1'b0;
            act_q    <= 1'b0;
            err_q    <= 1'b0;
        end else if (frame_sync) begin
            base_q  <= LW'(STEP * int'(cfg_eff.sc));
            cnt_q   <= LW'(STEP * (int'(cfg_eff.nc) + 1));
            rev_q   <= cfg_eff.rev;
            armed_q <= 1'b1;
            act_q   <= 1'b0;
            if (cfg_eff.tri3) begin
                step_q   <= 2'd3;
                tstart_q <= fld_q;
                t_q      <= LW'(fld_q);
                fld_q    <= (fld_q == 2'd2) ? 2'd0 : fld_q + 2'd1;
            end else begin
                step_q   <= 2'd1;
                tstart_q <= 2'd0;
                t_q      <= '0;
                fld_q    <= 2'd0;
            end
            if (cfg_bad) err_q <= 1'b1;
        end else if (line_tick) begin
            if (armed_q) begin
                armed_q <= 1'b0;
                act_q   <= 1'b1;
            end else if (act_q) begin
                if (t_next >= {1'b0, cnt_q}) act_q <= 1'b0;
                else                         t_q   <= t_next[LW-1:0];
            end
        end
    end

    assign offs      = rev_q ? (cnt_q - LW'(1) - t_q) : t_q;
    assign sel_line  = base_q + offs;
    assign sel_valid = act_q;
    assign is_first  = act_q && (t_q == LW'(tstart_q));
    assign is_last   = act_q && (t_next >= {1'b0, cnt_q});
    assign cfg_err   = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R8
    AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (t_q < cnt_q)); // R7
    AST_LINE_ON_PANEL: assert property (@(posedge clk) disable iff (rst)
        act_q |-> ({1'b0, sel_line} < (LW+1)'(TOTAL))); // R3
    AST_ARM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(armed_q && act_q)); // R2
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
        (act_q && $past(act_q) && $past(line_tick) && !$past(frame_sync))
        |-> (t_q == $past(t_q) + LW'(step_q))); // R5
endmodule

// File: rtl/gls_outdrv.sv
module gls_outdrv
    import gls_pkg::*;
#(
    parameter int N_LINES = 120,
    parameter int LW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_valid,
    input  logic [LW-1:0]      sel_line,
    input  logic               is_first,
    input  logic               is_last,
    input  logic               master,
    input  logic               disp_en,
    input  logic               sleep,
    input  logic               gate_on,
    input  logic               dummy_en,
    output logic [2*N_LINES-1:0] gate_lvl,
    output logic [3:0]         dummy_lvl
);
    logic [N_LINES-1:0] sel_vec;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        localparam logic [LW-1:0] IDX_M = LW'(i);
        localparam logic [LW-1:0] IDX_S = LW'(N_LINES + i);
        logic hit;
        assign hit = sel_valid && (sel_line == (master ? IDX_M : IDX_S));
        assign gate_lvl[2*i +: 2] =
            apply_ovr(hit ? LV_SEL : LV_OFF, sleep, disp_en, gate_on);
        assign sel_vec[i] = (gate_lvl[2*i +: 2] == LV_SEL);
    end

    assign dummy_lvl[1:0] =
        apply_ovr((dummy_en && is_first) ? LV_SEL : LV_OFF, sleep, disp_en, gate_on);
    assign dummy_lvl[3:2] =
        apply_ovr((dummy_en && is_last) ? LV_SEL : LV_OFF, sleep, disp_en, gate_on);

    AST_ONE_LINE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_vec)); // R1
    AST_BLANK_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (!disp_en || sleep) |-> (sel_vec == '0)); // R9
endmodule

// File: rtl/gate_line_scanner.sv
module gate_line_scanner
    import gls_pkg::*;
#(
    parameter int N_LINES = 120,
    parameter int STEP    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_sync,
    input  logic                 line_tick,
    input  logic                 master,
    input  logic                 disp_en,
    input  logic                 sleep,
    input  logic                 gate_on,
    input  logic                 dummy_en,
    input  logic [4:0]           cfg_start,
    input  logic [4:0]           cfg_lines,
    input  logic                 cfg_rev,
    input  logic [1:0]           cfg_fld,
    output logic [2*N_LINES-1:0] gate_lvl,
    output logic [3:0]           dummy_lvl,
    output logic                 cfg_err
);
    localparam int TOTAL    = 2 * N_LINES;
    localparam int MAX_CODE = TOTAL / STEP - 1;
    localparam int LW       = $clog2(TOTAL + 1);

    cfg_s          cfg_eff;
    logic          cfg_bad, sel_valid, is_first, is_last;
    logic [LW-1:0] sel_line;

    gls_cfg_clamp #(.MAX_CODE(MAX_CODE)) clamp_i (
        .raw_sc (cfg_start),
        .raw_nc (cfg_lines),
        .raw_rev(cfg_rev),
        .raw_fld(cfg_fld),
        .eff    (cfg_eff),
        .bad    (cfg_bad)
    );

    gls_seq #(.TOTAL(TOTAL), .STEP(STEP), .LW(LW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .line_tick (line_tick),
        .cfg_eff   (cfg_eff),
        .cfg_bad   (cfg_bad),
        .sel_valid (sel_valid),
        .sel_line  (sel_line),
        .is_first  (is_first),
        .is_last   (is_last),
        .cfg_err   (cfg_err)
    );

    gls_outdrv #(.N_LINES(N_LINES), .LW(LW)) drv_i (
        .clk      (clk),
        .rst      (rst),
        .sel_valid(sel_valid),
        .sel_line (sel_line),
        .is_first (is_first),
        .is_last  (is_last),
        .master   (master),
        .disp_en  (disp_en),
        .sleep    (sleep),
        .gate_on  (gate_on),
        .dummy_en (dummy_en),
        .gate_lvl (gate_lvl),
        .dummy_lvl(dummy_lvl)
    );

    AST_CLAMP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg_eff.nc != '0) &&
        (int'(cfg_eff.sc) + int'(cfg_eff.nc) <= MAX_CODE)); // R8
endmodule

// File: tb/gate_line_scanner_tb_top.sv
`timescale 1ns/1ps
module gate_line_scanner_tb_top;
    localparam int N = 120;

    logic clk = 1'b0, rst = 1'b1;
    logic frame_sync = 0, line_tick = 0, master = 1, disp_en = 1, sleep = 0;
    logic gate_on = 1, dummy_en = 0, cfg_rev = 0;
    logic [4:0] cfg_start = 0, cfg_lines = 29;
    logic [1:0] cfg_fld = 2'b01;
    logic [2*N-1:0] gate_lvl;
    logic [3:0] dummy_lvl;
    logic cfg_err;

    int checks = 0, errors = 0;
    int eS = 0, eC = 240, eStep = 1, eK = 0, eRev = 0, nt = 0, fcnt = 0;
    bit eErr = 0, done = 0;

    always #4 clk = ~clk;

    gate_line_scanner dut_i (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .line_tick(line_tick),
        .master(master), .disp_en(disp_en), .sleep(sleep), .gate_on(gate_on),
        .dummy_en(dummy_en), .cfg_start(cfg_start), .cfg_lines(cfg_lines),
        .cfg_rev(cfg_rev), .cfg_fld(cfg_fld), .gate_lvl(gate_lvl),
        .dummy_lvl(dummy_lvl), .cfg_err(cfg_err)
    );

    function automatic logic [1:0] ovr(logic [1:0] v);
        if (sleep) return 2'b00;
        if (!disp_en && !gate_on) return 2'b00;
        if (!disp_en) return 2'b01;
        return v;
    endfunction

    function automatic int cur_t();
        return eK + (nt - 1) * eStep;
    endfunction

    function automatic int exp_line();
        int t;
        if (nt == 0) return -1;
        t = cur_t();
        if (t >= eC) return -1;
        return eS + (eRev != 0 ? eC - 1 - t : t);
    endfunction

    function automatic logic [2*N-1:0] exp_gate();
        logic [2*N-1:0] v;
        int base, ln;
        base = master ? 0 : N;
        ln = exp_line();
        for (int i = 0; i < N; i++)
            v[2*i +: 2] = ovr((ln == base + i) ? 2'b10 : 2'b01);
        return v;
    endfunction

    function automatic logic [3:0] exp_dummy();
        logic [1:0] d0, d1;
        bit valid;
        valid = exp_line() >= 0;
        d0 = (dummy_en && valid && nt == 1) ? 2'b10 : 2'b01;
        d1 = (dummy_en && valid && cur_t() + eStep >= eC) ? 2'b10 : 2'b01;
        return {ovr(d1), ovr(d0)};
    endfunction

    task automatic check(string tag);
        logic [2*N-1:0] eg;
        logic [3:0] ed;
        eg = exp_gate();
        ed = exp_dummy();
        checks++;
        if (gate_lvl !== eg || dummy_lvl !== ed || cfg_err !== eErr) begin
            errors++;
            $display("FAIL %s: gate=%h dummy=%h err=%b expected gate=%h dummy=%h err=%b (line %0d)",
                     tag, gate_lvl, dummy_lvl, cfg_err, eg, ed, eErr, exp_line());
        end
    endtask

    task automatic model_sync(int sc, int nc, int rev, int fld);
        int ncE, scE;
        ncE = (nc == 0) ? 1 : (nc > 29 ? 29 : nc);
        scE = (sc > 29 - ncE) ? 29 - ncE : sc;
        if (nc != ncE || sc != scE || (fld % 2) == 0) eErr = 1;
        eS = 8 * scE;
        eC = 8 * (ncE + 1);
        eRev = rev;
        if (fld >= 2) begin
            eStep = 3; eK = fcnt; fcnt = (fcnt + 1) % 3;
        end else begin
            eStep = 1; eK = 0; fcnt = 0;
        end
        nt = 0;
    endtask

    task automatic sync(int sc, int nc, int rev, int fld, string tag);
        @(negedge clk);
        cfg_start = 5'(sc); cfg_lines = 5'(nc); cfg_rev = rev[0]; cfg_fld = 2'(fld);
        frame_sync = 1;
        @(negedge clk);
        frame_sync = 0;
        model_sync(sc, nc, rev, fld);
        #1 check(tag);
    endtask

    task automatic tick(string tag);
        @(negedge clk);
        line_tick = 1;
        @(negedge clk);
        line_tick = 0;
        nt++;
        #1 check(tag);
    endtask

    task automatic run_frame(string tag);
        int n;
        n = eC / eStep + 3;
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0ffee));
        repeat (3) @(negedge clk);
        rst = 0;
        #1 check("R1 reset");

        // default full window as master, then as slave
        sync(0, 29, 0, 1, "R2");
        run_frame("R3 R6 master");
        master = 0;
        sync(0, 29, 0, 1, "R2");
        run_frame("R6 slave");

        // reverse, partial window, spare markers
        dummy_en = 1;
        master = 0;
        sync(20, 5, 1, 1, "R4");
        run_frame("R4 R11 reverse");
        master = 1;
        sync(2, 3, 0, 1, "R3");
        run_frame("R11 R7 forward");

        // three fields, wrap of the field index
        for (int f = 0; f < 4; f++) begin
            sync(0, 3, f % 2, 3, "R5");
            run_frame("R5 three-field");
        end
        sync(0, 3, 0, 1, "R5 back to single");
        run_frame("R5 single");

        // frame sync and line strobe in the same cycle
        tick("R2");
        @(negedge clk);
        frame_sync = 1; line_tick = 1;
        @(negedge clk);
        frame_sync = 0; line_tick = 0;
        model_sync(0, 3, 0, 1);
        #1 check("R2 sync wins");
        tick("R2 first after sync");

        // mid-frame setting change ignored
        tick("R12");
        cfg_start = 5'd9; cfg_lines = 5'd1; cfg_rev = 1; cfg_fld = 2'b11;
        tick("R12 change ignored");
        tick("R12 change ignored");

        // asynchronous blanking between clock edges
        @(posedge clk); #2;
        disp_en = 0; #1 check("R9 off blank");
        gate_on = 0; #1 check("R9 ground blank");
        disp_en = 1; #1 check("R9 gate_on low alone");
        gate_on = 1; #1 check("R9 released");

        // sleep keeps position
        sleep = 1; #1 check("R10 sleep ground");
        repeat (5) @(negedge clk);
        #1 check("R10 sleep held");
        sleep = 0; #1 check("R10 wake same line");
        tick("R10 continue");

        // clamps and sticky flag
        sync(3, 0, 0, 1, "R8 length code 0");
        run_frame("R8 len 0");
        sync(0, 31, 0, 1, "R8 length above max");
        sync(31, 10, 1, 1, "R8 start too far");
        run_frame("R8 start clamp");
        sync(0, 3, 0, 0, "R8 fld 00");
        run_frame("R8 fld 00");
        sync(0, 3, 0, 2, "R8 fld 10");
        run_frame("R8 fld 10");
        sync(1, 2, 0, 1, "R8 sticky on legal frame");

        // random frames
        for (int r = 0; r < 30; r++) begin
            master = 1'($urandom % 2);
            dummy_en = 1'($urandom % 2);
            sync(int'($urandom % 32), int'($urandom % 32), int'($urandom % 2),
                 int'($urandom % 4), "R3 random");
            run_frame("R1 R4 R5 R6 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule